// File: doc/BRIEF.md
# Programmable Baud Divisor Generator

This block turns a fast reference clock into a single-cycle enable pulse that fires at sixteen times the chosen serial bit rate. The serial transmitter and receiver both use this pulse as their oversampling tick. The bit rate counts every bit on the line: start, data, parity and stop bits. The tick rate is the reference frequency divided by a 16-bit divisor. For example, with an 18.432 MHz reference, a divisor of 30 gives a 38,400 baud line, and a divisor of 10,473 gives roughly 110 baud.

Software writes the divisor as two bytes through a small byte-wide register port. The low byte sits at offset 0 and the high byte at offset 1. These two offsets are shared with the data path. They reach the divisor only while an access bit is set. That access bit is bit 7 of the line control register at offset 3. Every accepted divisor byte write reloads the internal down-counter, so a new rate applies from the next period on. A divisor of zero stops the tick.

Top module: `baud_div_gen`

## Requirements
- R1: After a synchronous active-low reset, both divisor bytes and the access bit read as zero and `tick_16x` stays low.
- R2: A write to offset 3 stores data bit 7 as the access bit. A read of offset 3 returns the access bit in bit 7 and zeros in bits 6..0.
- R3: While the access bit is 1, writes to offset 0 set the low divisor byte and writes to offset 1 set the high byte. Reads of those offsets return the stored bytes.
- R4: While the access bit is 0, writes to offsets 0 and 1 leave the divisor and the tick period unchanged, and reads of those offsets return zero.
- R5: With a divisor N of 2 or more, `tick_16x` is high for exactly one reference cycle out of every N.
- R6: With a divisor of 0, `tick_16x` never rises.
- R7: With a divisor of 1, `tick_16x` is high on every reference cycle.
- R8: After an accepted divisor byte write on clock edge E, the first tick is high in the cycle that follows edge E+N, where N is the new divisor. This holds even when the write falls mid-period.
- R9: A tick never lasts two consecutive cycles while the divisor is greater than 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low master reset |
| reg_wr | input | 1 | Register write strobe, sampled on the rising edge |
| reg_addr | input | 3 | Register offset for reads and writes |
| reg_wdata | input | 8 | Write data byte |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| tick_16x | output | 1 | One-cycle enable pulse at 16x the baud rate |

## Verification
Register writes take effect on the edge that samples them. Read data is combinational, so the bench drives the address at a falling edge and samples a moment later in the same cycle. After an accepted divisor write on edge E, the reload is applied on edge E+1 and the first tick is due in the cycle that follows edge E+N. The bench counts falling edges from the write and requires the first tick at count N and the next one N counts later. Suppression, zero-divisor and reset checks watch `tick_16x` for a fixed window of cycles and require it to stay low throughout.

// File: rtl/baud_div_pkg.sv
// Package: shared offsets and widths for the baud divisor generator.
// Assumes a byte-wide register port and a divisor of two bytes.
package baud_div_pkg;
    localparam int unsigned OFF_DIV_LO   = 0;  // low divisor byte (gated)
    localparam int unsigned OFF_DIV_HI   = 1;  // high divisor byte (gated)
    localparam int unsigned OFF_LINE_CTL = 3;  // holds the access bit in its MSB
    localparam int unsigned DIV_BYTES    = 2;
endpackage

// File: rtl/baud_div_regs.sv
// Module: baud_div_regs
// Holds the divisor-access bit and the two divisor bytes. Emits a one-cycle
// reload pulse, registered, after any accepted divisor byte write.
// Assumes writes are single-cycle strobes; reads are combinational.
module baud_div_regs
    import baud_div_pkg::*;
#(
    parameter int unsigned BYTE_W = 8,
    parameter int unsigned ADDR_W = 3,
    localparam int unsigned DIV_W = BYTE_W * DIV_BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata,
    output logic [DIV_W-1:0]  divisor,
    output logic              reload
);
    localparam logic [ADDR_W-1:0] A_LO  = ADDR_W'(OFF_DIV_LO);
    localparam logic [ADDR_W-1:0] A_HI  = ADDR_W'(OFF_DIV_HI);
    localparam logic [ADDR_W-1:0] A_LCR = ADDR_W'(OFF_LINE_CTL);

    logic              access_q;
    logic [BYTE_W-1:0] byte_q [DIV_BYTES];
    logic              hit_div;

    // Decode: is this a write that lands on a divisor byte?
    always_comb begin
        hit_div = wr_en && access_q && ((addr == A_LO) || (addr == A_HI));
    end

    // Access bit storage, written through the line control offset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            access_q <= 1'b0;
        end else if (wr_en && addr == A_LCR) begin
            access_q <= wdata[BYTE_W-1];
        end
    end

    // One storage byte per divisor slice, selected by offset.
    for (genvar b = 0; b < DIV_BYTES; b++) begin : g_byte
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                byte_q[b] <= '0;
            end else if (hit_div && addr == ADDR_W'(OFF_DIV_LO + b)) begin
                byte_q[b] <= wdata;
            end
        end
        assign divisor[b*BYTE_W +: BYTE_W] = byte_q[b];
    end

    // Reload pulse trails the accepted write by one edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reload <= 1'b0;
        end else begin
            reload <= hit_div;
        end
    end

    // Read mux: divisor bytes only while access is set.
    always_comb begin
        rdata = '0;
        if (addr == A_LCR) begin
            rdata[BYTE_W-1] = access_q;
        end else if (access_q && addr == A_LO) begin
            rdata = byte_q[0];
        end else if (access_q && addr == A_HI) begin
            rdata = byte_q[1];
        end
    end

    // R4: a locked write must not move the divisor.
    assert_locked_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !access_q && (addr == A_LO || addr == A_HI)) |=> (divisor == $past(divisor)));

    // R2: the access bit follows the data MSB written to the control offset.
    assert_access_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_LCR) |=> (access_q == $past(wdata[BYTE_W-1])));

    // R3: an accepted write is followed by a reload pulse.
    assert_reload_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && access_q && (addr == A_LO || addr == A_HI)) |=> reload);
endmodule

// File: rtl/baud_div_counter.sv
// Module: baud_div_counter
// Down-counter that raises a one-cycle tick every DIVISOR reference cycles.
// A reload pulse restarts the count from the current divisor; zero stops it.
module baud_div_counter #(
    parameter int unsigned DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] divisor,
    input  logic             reload,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;
    logic             div_zero;

    // Flag the stopped state.
    always_comb begin
        div_zero = (divisor == '0);
    end

    // Count down, restarting on reload or on the tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (div_zero) begin
            cnt_q <= '0;
        end else if (reload || cnt_q == '0) begin
            cnt_q <= divisor - 1'b1;
        end else begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Tick on terminal count, held off in the reload cycle.
    always_comb begin
        tick = !reload && !div_zero && (cnt_q == '0);
    end

    assert_no_tick_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (divisor == '0) |-> !tick);

    assert_reload_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (reload && divisor > 1) |=> !tick);

    assert_single_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && divisor > 1) |=> !tick);

    assert_every_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (divisor == 1 && !reload) |=> (tick || reload));
endmodule

// File: rtl/baud_div_gen.sv
// Module: baud_div_gen (top)
// Register-programmed baud divisor producing a 16x oversampling enable.
// Assumes one reference clock domain and a synchronous active-low reset.
module baud_div_gen
    import baud_div_pkg::*;
#(
    parameter int unsigned BYTE_W = 8,
    parameter int unsigned ADDR_W = 3,
    localparam int unsigned DIV_W = BYTE_W * DIV_BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [BYTE_W-1:0] reg_wdata,
    output logic [BYTE_W-1:0] reg_rdata,
    output logic              tick_16x
);
    logic [DIV_W-1:0] divisor;
    logic             reload;

    baud_div_regs #(.BYTE_W(BYTE_W), .ADDR_W(ADDR_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .rdata   (reg_rdata),
        .divisor (divisor),
        .reload  (reload)
    );

    baud_div_counter #(.DIV_W(DIV_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .divisor (divisor),
        .reload  (reload),
        .tick    (tick_16x)
    );

    // R1: the cycle after reset is applied, no tick.
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> !tick_16x);
endmodule

// File: tb/baud_div_gen_tb.sv
module baud_div_gen_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       tick_16x;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    baud_div_gen dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tick_16x(tick_16x)
    );

    // {high byte, low byte, expected period}
    localparam logic [31:0] VEC [8] = '{
        {8'h00, 8'h01, 16'd1},   {8'h00, 8'h02, 16'd2},
        {8'h00, 8'h03, 16'd3},   {8'h00, 8'h05, 16'd5},
        {8'h00, 8'h10, 16'd16},  {8'h00, 8'h1E, 16'd30},
        {8'h01, 8'h00, 16'd256}, {8'h01, 8'h2C, 16'd300}
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output int v);
        @(negedge clk);
        reg_addr = a;
        #1 v = int'(reg_rdata);
    endtask

    // Falling edges until tick is seen (0 if none within limit).
    task automatic wait_tick(input int limit, output int k);
        k = 0;
        for (int i = 1; i <= limit; i++) begin
            @(negedge clk);
            if (tick_16x) begin k = i; break; end
        end
    endtask

    task automatic count_ticks(input int cycles, output int n);
        n = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (tick_16x) n++;
        end
    endtask

    initial begin
        #2_000_000;
        errors++; checks++;
        $display("FAIL watchdog R5 actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int v, k, n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd(3'd3, v); check("R1 lcr", v, 0);
        wr(3'd3, 8'h80);
        rd(3'd0, v); check("R1 lo", v, 0);
        rd(3'd1, v); check("R1 hi", v, 0);
        count_ticks(40, n); check("R1 no tick", n, 0);

        // R2: access bit readback
        rd(3'd3, v); check("R2 set", v, 8'h80);
        wr(3'd3, 8'h7F);
        rd(3'd3, v); check("R2 clear", v, 0);
        wr(3'd3, 8'h80);

        // Vector table: R3 readback, R8 first tick, R5/R7 period
        for (int i = 0; i < 8; i++) begin
            int exp_p;
            exp_p = int'(VEC[i][15:0]);
            wr(3'd1, VEC[i][31:24]);
            wr(3'd0, VEC[i][23:16]);
            wait_tick(2000, k); check("R8 first tick", k, exp_p);
            wait_tick(2000, k); check(exp_p == 1 ? "R7 period" : "R5 period", k, exp_p);
            rd(3'd0, v); check("R3 lo", v, int'(VEC[i][23:16]));
            rd(3'd1, v); check("R3 hi", v, int'(VEC[i][31:24]));
        end

        // R9: divisor 3 -> one pulse per 3 cycles over 30 cycles
        wr(3'd1, 8'h00); wr(3'd0, 8'h03);
        wait_tick(20, k);
        count_ticks(30, n); check("R9 pulses", n, 10);
        count_ticks(1, n); check("R9 width", n, 0);

        // R4: locked writes ignored
        wr(3'd3, 8'h00);
        rd(3'd0, v); check("R4 read lo locked", v, 0);
        wr(3'd0, 8'h09);
        wr(3'd1, 8'h04);
        wait_tick(20, k);
        wait_tick(20, k); check("R4 period kept", k, 3);
        wr(3'd3, 8'h80);
        rd(3'd0, v); check("R4 lo kept", v, 3);
        rd(3'd1, v); check("R4 hi kept", v, 0);

        // R8: mid-period reload
        wr(3'd1, 8'h01); wr(3'd0, 8'h2C);
        repeat (10) @(negedge clk);
        wr(3'd1, 8'h00);
        wr(3'd0, 8'h04);
        wait_tick(1000, k); check("R8 mid reload", k, 4);

        // R6: divisor zero
        wr(3'd0, 8'h00);
        count_ticks(60, n); check("R6 no tick", n, 0);

        // R1: reset while running
        wr(3'd0, 8'h05);
        repeat (7) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        count_ticks(30, n); check("R1 tick after reset", n, 0);
        rd(3'd3, v); check("R1 lcr after reset", v, 0);
        wr(3'd3, 8'h80);
        rd(3'd0, v); check("R1 lo after reset", v, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule